// File: doc/BRIEF.md
# Open Page Tracking Table

This block keeps a record of which SDRAM pages are open across a set of chip-select rows. Each row holds one open-page entry per internal bank. A row is configured as either a two-bank device or a four-bank device. A memory controller presents each pending access to the lookup port. One clock later it receives a classification of that access:

- a page hit: the bank is open on the same page;
- a bank-idle miss: the bank is closed, so an activate is needed;
- a page conflict: the bank is open on another page, so a precharge and an activate are needed;
- an invalid bank: the bank index is beyond what the row is configured for.

The command sequencer reports every activate, precharge, auto-precharge and precharge-all command it issues on the update port. The table tracks the memory state from these reports.

Pages are never closed because ownership of the memory moves from one requester to another. No limit applies to how many rows or banks hold open pages together, and the tracking cannot be switched off. The lookup is registered, so the decision for the next request is formed while the current access is still running. An update reported in the same cycle as a lookup is taken into account by that lookup.

Top module: `open_page_table`

## Requirements
- R1: After reset every bank of every row is closed: every legal lookup is classified bank-idle (class code 1), and `res_valid` is 0 while reset is held.
- R2: A lookup presented with `lk_valid` high yields `res_valid` high exactly one clock edge later. At that point `res_cs` and `res_bank` echo the lookup's row and bank. Without a lookup, `res_valid` is 0 after that edge.
- R3: After an activate (update command code 0) to a row, bank and page, a lookup of that row, bank and page is classified page hit (class code 0).
- R4: A lookup of an open bank with a page different from the one stored is classified page conflict (class code 2).
- R5: A precharge (command code 1) or auto-precharge (command code 2) closes only the addressed bank of the addressed row. A later lookup of that bank is bank-idle.
- R6: A precharge-all (command code 3) closes every bank of the addressed row, whatever the bank field holds. Banks of other rows are unaffected.
- R7: Row r is four-bank when `row_four[r]` is 1, and two-bank otherwise. On a two-bank row, a lookup of bank 2 or 3 is classified invalid bank (class code 3). An activate or a single-bank precharge to such a bank changes no entry.
- R8: An update reported in the same cycle as a lookup is reflected in that lookup's result.
- R9: All rows and all legal banks may hold open pages at the same time. Each entry changes only on updates that address it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_four | input | NUM_ROWS | Per-row bank-count select: 1 = four banks, 0 = two banks |
| lk_valid | input | 1 | Lookup request present |
| lk_cs | input | clog2(NUM_ROWS) | Lookup row (chip select) |
| lk_bank | input | clog2(MAX_BANKS) | Lookup bank |
| lk_page | input | PAGE_W | Lookup page (row address) |
| up_valid | input | 1 | Command report present |
| up_cmd | input | 2 | 0 activate, 1 precharge, 2 auto-precharge, 3 precharge-all |
| up_cs | input | clog2(NUM_ROWS) | Row addressed by the command |
| up_bank | input | clog2(MAX_BANKS) | Bank addressed by the command |
| up_page | input | PAGE_W | Page opened by an activate |
| res_valid | output | 1 | Classification present |
| res_cs | output | clog2(NUM_ROWS) | Row of the classified lookup |
| res_bank | output | clog2(MAX_BANKS) | Bank of the classified lookup |
| res_class | output | 2 | 0 hit, 1 bank-idle, 2 conflict, 3 invalid bank |

## Verification
A classification is due on the first rising clock edge after its lookup is presented. A reported command takes effect at that same edge, and it is already visible to a lookup presented in the same cycle. The bench drives each lookup and update at a falling edge. It applies the update to its own open-page model before computing the expected class. It then samples the result one time unit after the following rising edge, so every comparison lands in the single cycle where the result is due. Invalid-bank writes are shown to have had no effect by switching the row to four-bank afterwards and confirming that those banks still read as idle.

// File: rtl/opt_pkg.sv
// Package: shared encodings for the open page tracking table.
// Assumes two-bit command and class fields on the block's ports.
package opt_pkg;

    typedef enum logic [1:0] {
        CMD_ACT    = 2'd0,
        CMD_PRE    = 2'd1,
        CMD_APRE   = 2'd2,
        CMD_PREALL = 2'd3
    } upd_cmd_e;

    typedef enum logic [1:0] {
        CLS_HIT      = 2'd0,
        CLS_IDLE     = 2'd1,
        CLS_CONFLICT = 2'd2,
        CLS_BADBANK  = 2'd3
    } acc_cls_e;

endpackage

// File: rtl/opt_bank_entry.sv
// Module: one bank entry of the table (valid flag plus open page).
// Offers its next-state value so a same-cycle lookup can see an update.
// Assumes open_en and close_en are never both high.
module opt_bank_entry #(
    parameter int PAGE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_en,
    input  logic              close_en,
    input  logic [PAGE_W-1:0] page_in,
    output logic              nxt_valid,
    output logic [PAGE_W-1:0] nxt_page
);
    logic              cur_valid;
    logic [PAGE_W-1:0] cur_page;

    // Next state: an activate opens, a precharge closes, otherwise hold.
    always_comb begin
        nxt_valid = cur_valid;
        nxt_page  = cur_page;
        if (open_en) begin
            nxt_valid = 1'b1;
            nxt_page  = page_in;
        end else if (close_en) begin
            nxt_valid = 1'b0;
        end
    end

    // Entry storage, cleared to closed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_valid <= 1'b0;
            cur_page  <= '0;
        end else begin
            cur_valid <= nxt_valid;
            cur_page  <= nxt_page;
        end
    end
endmodule

// File: rtl/opt_update_decode.sv
// Module: turns one command report into per-entry open and close strobes.
// Entry index is row*MAX_BANKS+bank. Banks in the upper half of a
// two-bank row take single-bank commands as no-ops; precharge-all
// clears every bank of its row.
module opt_update_decode #(
    parameter int NUM_ROWS  = 8,
    parameter int MAX_BANKS = 4
) (
    input  logic                          up_valid,
    input  logic [1:0]                    up_cmd,
    input  logic [$clog2(NUM_ROWS)-1:0]   up_cs,
    input  logic [$clog2(MAX_BANKS)-1:0]  up_bank,
    input  logic [NUM_ROWS-1:0]           row_four,
    output logic [NUM_ROWS*MAX_BANKS-1:0] open_vec,
    output logic [NUM_ROWS*MAX_BANKS-1:0] close_vec
);
    import opt_pkg::*;
    localparam int CS_W = $clog2(NUM_ROWS);
    localparam int BK_W = $clog2(MAX_BANKS);

    logic is_act, is_single_close, is_all_close;

    // Command type decode.
    always_comb begin
        is_act          = up_valid && (up_cmd == CMD_ACT);
        is_single_close = up_valid && ((up_cmd == CMD_PRE) || (up_cmd == CMD_APRE));
        is_all_close    = up_valid && (up_cmd == CMD_PREALL);
    end

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        logic row_sel;
        assign row_sel = (up_cs == CS_W'(r));
        for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
            logic bank_ok;
            logic bank_sel;
            if (b < MAX_BANKS / 2) begin : g_low
                assign bank_ok = 1'b1;
            end else begin : g_high
                assign bank_ok = row_four[r];
            end
            assign bank_sel = row_sel && (up_bank == BK_W'(b)) && bank_ok;
            assign open_vec[r*MAX_BANKS+b]  = is_act && bank_sel;
            assign close_vec[r*MAX_BANKS+b] = (is_single_close && bank_sel)
                                            || (is_all_close && row_sel);
        end
    end
endmodule

// File: rtl/opt_classify.sv
// Module: combinational lookup of one row/bank against the table's
// next state, producing the access class. Assumes NUM_ROWS and
// MAX_BANKS are powers of two so {cs,bank} indexes the entry.
module opt_classify #(
    parameter int NUM_ROWS  = 8,
    parameter int MAX_BANKS = 4,
    parameter int PAGE_W    = 13
) (
    input  logic [$clog2(NUM_ROWS)-1:0]               lk_cs,
    input  logic [$clog2(MAX_BANKS)-1:0]              lk_bank,
    input  logic [PAGE_W-1:0]                         lk_page,
    input  logic [NUM_ROWS-1:0]                       row_four,
    input  logic [NUM_ROWS*MAX_BANKS-1:0]             ent_valid,
    input  logic [NUM_ROWS*MAX_BANKS-1:0][PAGE_W-1:0] ent_page,
    output logic [1:0]                                cls
);
    import opt_pkg::*;
    localparam int CS_W  = $clog2(NUM_ROWS);
    localparam int BK_W  = $clog2(MAX_BANKS);
    localparam int IDX_W = CS_W + BK_W;

    logic [IDX_W-1:0] idx;
    logic             legal;

    // Entry select and bank-range check.
    always_comb begin
        idx   = {lk_cs, lk_bank};
        legal = row_four[lk_cs] || ({1'b0, lk_bank} < (BK_W+1)'(MAX_BANKS / 2));
    end

    // Class decision in priority order: invalid, idle, hit, conflict.
    always_comb begin
        if (!legal)                          cls = CLS_BADBANK;
        else if (!ent_valid[idx])            cls = CLS_IDLE;
        else if (ent_page[idx] == lk_page)   cls = CLS_HIT;
        else                                 cls = CLS_CONFLICT;
    end
endmodule

// File: rtl/open_page_table.sv
// Module: open page tracking table top. Holds one entry per bank of
// every row, updated from command reports, and returns a registered
// class for each lookup one edge after it is presented. Lookups see
// same-cycle updates. Pages stay open until a precharge is reported.
module open_page_table #(
    parameter int NUM_ROWS  = 8,
    parameter int MAX_BANKS = 4,
    parameter int PAGE_W    = 13
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_ROWS-1:0]          row_four,
    input  logic                         lk_valid,
    input  logic [$clog2(NUM_ROWS)-1:0]  lk_cs,
    input  logic [$clog2(MAX_BANKS)-1:0] lk_bank,
    input  logic [PAGE_W-1:0]            lk_page,
    input  logic                         up_valid,
    input  logic [1:0]                   up_cmd,
    input  logic [$clog2(NUM_ROWS)-1:0]  up_cs,
    input  logic [$clog2(MAX_BANKS)-1:0] up_bank,
    input  logic [PAGE_W-1:0]            up_page,
    output logic                         res_valid,
    output logic [$clog2(NUM_ROWS)-1:0]  res_cs,
    output logic [$clog2(MAX_BANKS)-1:0] res_bank,
    output logic [1:0]                   res_class
);
    localparam int N_ENT = NUM_ROWS * MAX_BANKS;

    logic [N_ENT-1:0]             open_vec;
    logic [N_ENT-1:0]             close_vec;
    logic [N_ENT-1:0]             nxt_valid;
    logic [N_ENT-1:0][PAGE_W-1:0] nxt_page;
    logic [1:0]                   cls_now;

    opt_update_decode #(.NUM_ROWS(NUM_ROWS), .MAX_BANKS(MAX_BANKS)) u_dec (
        .up_valid (up_valid),
        .up_cmd   (up_cmd),
        .up_cs    (up_cs),
        .up_bank  (up_bank),
        .row_four (row_four),
        .open_vec (open_vec),
        .close_vec(close_vec)
    );

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        opt_bank_entry #(.PAGE_W(PAGE_W)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .open_en  (open_vec[e]),
            .close_en (close_vec[e]),
            .page_in  (up_page),
            .nxt_valid(nxt_valid[e]),
            .nxt_page (nxt_page[e])
        );
    end

    opt_classify #(.NUM_ROWS(NUM_ROWS), .MAX_BANKS(MAX_BANKS), .PAGE_W(PAGE_W)) u_cls (
        .lk_cs    (lk_cs),
        .lk_bank  (lk_bank),
        .lk_page  (lk_page),
        .row_four (row_four),
        .ent_valid(nxt_valid),
        .ent_page (nxt_page),
        .cls      (cls_now)
    );

    // Result register: one-cycle pipelined lookup outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_cs    <= '0;
            res_bank  <= '0;
            res_class <= '0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                res_cs    <= lk_cs;
                res_bank  <= lk_bank;
                res_class <= cls_now;
            end
        end
    end
endmodule

// File: rtl/opt_table_checker.sv
// Module: assertion checker for the open page tracking table, bound
// to every instance of the top module.
module opt_table_checker #(
    parameter int NUM_ROWS  = 8,
    parameter int MAX_BANKS = 4,
    parameter int PAGE_W    = 13
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_ROWS-1:0]          row_four,
    input logic                         lk_valid,
    input logic [$clog2(NUM_ROWS)-1:0]  lk_cs,
    input logic [$clog2(MAX_BANKS)-1:0] lk_bank,
    input logic [PAGE_W-1:0]            lk_page,
    input logic                         up_valid,
    input logic [1:0]                   up_cmd,
    input logic [$clog2(NUM_ROWS)-1:0]  up_cs,
    input logic [$clog2(MAX_BANKS)-1:0] up_bank,
    input logic [PAGE_W-1:0]            up_page,
    input logic                         res_valid,
    input logic [$clog2(NUM_ROWS)-1:0]  res_cs,
    input logic [$clog2(MAX_BANKS)-1:0] res_bank,
    input logic [1:0]                   res_class
);
    localparam int BK_W = $clog2(MAX_BANKS);

    logic lk_legal;
    logic same_target;
    assign lk_legal    = row_four[lk_cs] || ({1'b0, lk_bank} < (BK_W+1)'(MAX_BANKS / 2));
    assign same_target = up_valid && lk_valid && (lk_cs == up_cs) && (lk_bank == up_bank);

    // R1: nothing is reported while reset is held.
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |=> !res_valid);

    // R2: result valid one edge after a lookup, row and bank echoed.
    a_r2_result_timing: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (res_valid == $past(lk_valid)));

    a_r2_result_echo: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (res_cs == $past(lk_cs)) && (res_bank == $past(lk_bank)));

    // R7: out-of-range bank on a two-bank row is flagged.
    a_r7_bad_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_legal) |=> (res_class == 2'd3));

    // R8: same-cycle activate of the looked-up page is a hit.
    a_r8_fwd_activate: assert property (@(posedge clk) disable iff (!rst_n)
        (same_target && lk_legal && (up_cmd == 2'd0) && (lk_page == up_page))
        |=> (res_class == 2'd0));

    // R8: same-cycle single-bank precharge leaves the bank idle.
    a_r8_fwd_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        (same_target && lk_legal && ((up_cmd == 2'd1) || (up_cmd == 2'd2)))
        |=> (res_class == 2'd1));

    // R6: same-cycle precharge-all of the looked-up row leaves it idle.
    a_r6_fwd_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && lk_valid && lk_legal && (up_cmd == 2'd3) && (lk_cs == up_cs))
        |=> (res_class == 2'd1));
endmodule

bind open_page_table opt_table_checker #(
    .NUM_ROWS (NUM_ROWS),
    .MAX_BANKS(MAX_BANKS),
    .PAGE_W   (PAGE_W)
) u_chk (.*);

// File: tb/open_page_table_test.sv
// Bench: sweeps every row and bank of the default configuration against
// an arithmetic open-page model, then runs a random mixed phase.
module open_page_table_test;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 8;
    localparam int NB = 4;
    localparam int PW = 13;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NR-1:0] row_four;
    logic          lk_valid;
    logic [2:0]    lk_cs;
    logic [1:0]    lk_bank;
    logic [PW-1:0] lk_page;
    logic          up_valid;
    logic [1:0]    up_cmd;
    logic [2:0]    up_cs;
    logic [1:0]    up_bank;
    logic [PW-1:0] up_page;
    logic          res_valid;
    logic [2:0]    res_cs;
    logic [1:0]    res_bank;
    logic [1:0]    res_class;

    int checks = 0;
    int fails  = 0;

    logic          mv [NR][NB];
    logic [PW-1:0] mp [NR][NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    open_page_table #(.NUM_ROWS(NR), .MAX_BANKS(NB), .PAGE_W(PW)) uut (.*);

    function automatic logic legal(input int cs, input int b);
        return row_four[cs] || (b < NB/2);
    endfunction

    function automatic int page_of(input int cs, input int b);
        return cs*37 + b*5 + 1;
    endfunction

    task automatic check(input string tag, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, update the model, sample after the rising edge.
    task automatic step(input logic lv, input int lcs, input int lb, input int lp,
                        input logic uv, input int ucmd, input int ucs, input int ub,
                        input int upg, input string tag);
        int expc;
        @(negedge clk);
        lk_valid = lv; lk_cs = lcs[2:0]; lk_bank = lb[1:0]; lk_page = lp[PW-1:0];
        up_valid = uv; up_cmd = ucmd[1:0]; up_cs = ucs[2:0]; up_bank = ub[1:0];
        up_page = upg[PW-1:0];
        if (uv) begin
            if (ucmd == 3) begin
                for (int b = 0; b < NB; b++) mv[ucs][b] = 1'b0;
            end else if (legal(ucs, ub)) begin
                if (ucmd == 0) begin
                    mv[ucs][ub] = 1'b1;
                    mp[ucs][ub] = upg[PW-1:0];
                end else begin
                    mv[ucs][ub] = 1'b0;
                end
            end
        end
        if (!legal(lcs, lb))                   expc = 3;
        else if (!mv[lcs][lb])                 expc = 1;
        else if (mp[lcs][lb] == lp[PW-1:0])    expc = 0;
        else                                   expc = 2;
        @(posedge clk);
        #1;
        if (lv) begin
            check({tag, " valid/echo"}, res_valid && res_cs == lcs[2:0] && res_bank == lb[1:0],
                  {res_valid, res_cs, res_bank}, {1'b1, lcs[2:0], lb[1:0]});
            check({tag, " class"}, res_class == expc[1:0], res_class, expc);
        end else begin
            check({tag, " no result"}, !res_valid, res_valid, 0);
        end
        lk_valid = 1'b0;
        up_valid = 1'b0;
    endtask

    task automatic look(input int cs, input int b, input int p, input string tag);
        step(1'b1, cs, b, p, 1'b0, 0, 0, 0, 0, tag);
    endtask

    task automatic upd(input int cmd, input int cs, input int b, input int p, input string tag);
        step(1'b0, 0, 0, 0, 1'b1, cmd, cs, b, p, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < NR; r++)
            for (int b = 0; b < NB; b++) begin mv[r][b] = 1'b0; mp[r][b] = '0; end
        row_four = 8'b0101_0101;
        rst_n = 1'b0;
        lk_valid = 1'b1; lk_cs = '0; lk_bank = '0; lk_page = '0;
        up_valid = 1'b0; up_cmd = '0; up_cs = '0; up_bank = '0; up_page = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset output", !res_valid, res_valid, 0);
        @(negedge clk);
        lk_valid = 1'b0;
        rst_n = 1'b1;

        // R1 / R7: all entries idle, upper banks of two-bank rows invalid.
        for (int r = 0; r < NR; r++)
            for (int b = 0; b < NB; b++) look(r, b, 0, legal(r, b) ? "R1" : "R7");
        step(1'b0, 0, 0, 0, 1'b0, 0, 0, 0, 0, "R2");

        // R9 / R3: open every legal bank of every row, then hit each.
        for (int r = 0; r < NR; r++)
            for (int b = 0; b < NB; b++) upd(0, r, b, page_of(r, b), "R9");
        for (int r = 0; r < NR; r++)
            for (int b = 0; b < NB; b++) look(r, b, page_of(r, b), "R3");
        // R4: different page in every open bank.
        for (int r = 0; r < NR; r++)
            for (int b = 0; b < NB; b++) look(r, b, page_of(r, b) + 1, "R4");

        // R7: single-bank precharge to an invalid bank is ignored.
        upd(1, 1, 0, 0, "R7");
        upd(1, 1, 3, 0, "R7");
        look(1, 1, page_of(1, 1), "R7");

        // R5: precharge and auto-precharge close only their bank.
        upd(1, 0, 1, 0, "R5");
        upd(2, 2, 3, 0, "R5");
        for (int b = 0; b < NB; b++) look(0, b, page_of(0, b), "R5");
        for (int b = 0; b < NB; b++) look(2, b, page_of(2, b), "R5");

        // R6: precharge-all closes the whole row, neighbours untouched.
        upd(3, 4, 2, 0, "R6");
        for (int b = 0; b < NB; b++) look(4, b, page_of(4, b), "R6");
        for (int b = 0; b < NB; b++) look(5, b, page_of(5, b), "R6");

        // R8: same-cycle update is visible to the lookup.
        step(1'b1, 6, 0, 99, 1'b1, 0, 6, 0, 99, "R8");
        step(1'b1, 6, 0, 99, 1'b1, 2, 6, 0, 0, "R8");
        step(1'b1, 6, 1, 5, 1'b1, 3, 6, 0, 0, "R8");

        // R7: widen every row; banks written while invalid must be idle.
        row_four = 8'hFF;
        for (int r = 1; r < NR; r += 2)
            for (int b = NB/2; b < NB; b++) look(r, b, page_of(r, b), "R7");

        // R9: random mixed traffic against the model.
        for (int i = 0; i < 3000; i++) begin
            if (i == 1500) row_four = 8'b0011_1010;
            step(1'($urandom_range(0, 3) != 0), $urandom_range(0, NR-1), $urandom_range(0, NB-1),
                 $urandom_range(0, 3), 1'($urandom_range(0, 1)), $urandom_range(0, 3),
                 $urandom_range(0, NR-1), $urandom_range(0, NB-1), $urandom_range(0, 3), "R9");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule